// File: doc/BRIEF.md
# Clock Source Mux with Fractional Divider

This block picks one of up to sixteen incoming clock signals and derives a single peripheral clock from it. A control word chooses the source and gates the output. A divide word holds an unsigned fixed-point divisor, and the output runs at the selected input's rate times 2^FRAC_BITS divided by that divisor. A busy flag tells the caller whether the generator is currently running.

All logic runs in one fast system clock domain (`clk_i`). Source clocks must be slower than half the system rate. They are synchronised and edge-detected. A first-order phase accumulator takes in every edge of the selected source, both rising and falling, and toggles the output each time the accumulated phase reaches the divisor. When both divisor widths are set to zero, the block passes the selected source straight through. Source changes wait until the outgoing and incoming sources are both low, so the switch itself never creates an edge.

Top module: `clk_src_frac_div`

## Requirements
- R1: While the enable bit (`ctrl_i[4]`) is clear, `clk_o` stays low. No edge appears on it however the sources toggle.
- R2: `busy_o` equals the value of the enable bit sampled at the previous rising edge of `clk_i`.
- R3: The four-bit field `ctrl_i[3:0]` selects the source index into `src_clk_i`, and only the selected source sets the output rate.
- R4: Index 0 is tied to ground: selecting it gives no output edges, whatever `src_clk_i[0]` does. Index 1 is meant for the main oscillator.
- R5: The divisor is the concatenation of an integer part in `div_i[12 +: INT_BITS]` and a fraction in `div_i[12-FRAC_BITS +: FRAC_BITS]`. All other bits of `div_i` and `ctrl_i[31:5]` have no effect.
- R6: With divisor D ≥ 2^FRAC_BITS, the output frequency is f_in·2^FRAC_BITS/D. Each input edge adds 2^FRAC_BITS to an accumulator, and the output toggles when the accumulator reaches D.
- R7: A divisor of zero holds `clk_o` low.
- R8: A nonzero divisor below 2^FRAC_BITS (integer part zero) is treated as exactly 1.0, so the output runs at the input frequency.
- R9: With INT_BITS = FRAC_BITS = 0, the enabled output is the selected source, undivided.
- R10: A new selection takes effect only in a cycle where both the current and the requested source are low. The output toggles at most once per edge of the selected source.
- R11: During and immediately after reset, `clk_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all sources |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 32 | Control word: source select [3:0], enable [4] |
| div_i | input | 32 | Divide word holding the fixed-point divisor around bit 12 |
| src_clk_i | input | NUM_SRC | Candidate source clocks; bit 0 is ignored (ground) |
| clk_o | output | 1 | Divided peripheral clock |
| busy_o | output | 1 | High while the generator is enabled |

## Verification
The bench sweeps divisors with integer, half and quarter fractions across sources of different periods, and compares output edge counts over a fixed window with the rate computed from R6. A design that placed the field off by a bit, or decoded the stray bits that the bench sets around it, would show a rate off by a factor of two or more. The edge cases are covered directly: a zero divisor must stop the output rather than run at the largest ratio, and a sub-unity divisor must clamp rather than let the accumulator run away. Selecting index 0 must give silence even though the bench toggles that input pin. A pass-through instance shows that zero-width dividers neither stall nor halve the clock.

// File: rtl/clk_src_div_pkg.sv
package clk_src_div_pkg;
  localparam int REG_W       = 32;
  localparam int SEL_LSB     = 0;
  localparam int SEL_W       = 4;
  localparam int EN_BIT      = 4;
  localparam int DIV_POINT   = 12;
  localparam int MAX_SOURCES = 1 << SEL_W;
endpackage

// File: rtl/clk_src_sync.sv
module clk_src_sync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch #(
  parameter int N     = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     lvl_i,
  input  logic [SEL_W-1:0] sel_req_i,
  output logic             lvl_o
);
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_req_eff;
  logic             old_lvl, new_lvl, do_switch;

  // out-of-range requests fall back to the ground input
  assign sel_req_eff = (int'(sel_req_i) < N) ? sel_req_i : '0;
  assign old_lvl     = lvl_i[sel_q];
  assign new_lvl     = lvl_i[sel_req_eff];
  assign do_switch   = (sel_req_eff != sel_q) && !old_lvl && !new_lvl;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        sel_q <= '0;
    else if (do_switch) sel_q <= sel_req_eff;

  assign lvl_o = old_lvl;

  assert_quiet_switch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (!$past(old_lvl) && !$past(new_lvl)));

  assert_sel_tracks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (sel_q == $past(sel_req_eff)));
endmodule

// File: rtl/clk_frac_div.sv
module clk_frac_div #(
  parameter int INT_BITS  = 12,
  parameter int FRAC_BITS = 12,
  localparam int DW       = INT_BITS + FRAC_BITS,
  localparam int DWP      = (DW > 0) ? DW : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           lvl_i,
  input  logic [DWP-1:0] div_i,
  output logic           clk_o
);
  logic out_q;

  if (DW == 0) begin : g_pass
    logic unused_div;
    assign unused_div = ^div_i;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) out_q <= 1'b0;
      else         out_q <= en_i & lvl_i;

    assert_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(out_q) |-> $past(lvl_i));
  end else begin : g_acc
    localparam int AW = DW + 1;
    localparam logic [AW-1:0] ONE = AW'(1) << FRAC_BITS;

    logic [AW-1:0] acc_q, acc_sum, acc_rem, div_eff;
    logic          lvl_prev_q, ev, div_zero, hit;

    assign ev       = lvl_i ^ lvl_prev_q;
    assign div_zero = (div_i == '0);
    // sub-unity divisors clamp to 1.0
    assign div_eff  = ({1'b0, div_i} < ONE) ? ONE : {1'b0, div_i};
    assign acc_sum  = acc_q + ONE;
    assign hit      = (acc_sum >= div_eff);
    assign acc_rem  = acc_sum - div_eff;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) lvl_prev_q <= 1'b0;
      else         lvl_prev_q <= lvl_i;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        acc_q <= '0;
        out_q <= 1'b0;
      end else if (!en_i || div_zero) begin
        acc_q <= '0;
        out_q <= 1'b0;
      end else if (ev) begin
        if (hit) begin
          // divisor may have shrunk under a live accumulator
          acc_q <= (acc_rem >= div_eff) ? '0 : acc_rem;
          out_q <= ~out_q;
        end else begin
          acc_q <= acc_sum;
        end
      end else if (acc_q >= div_eff) begin
        acc_q <= '0;
      end

    assert_zero_div_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && div_zero) |=> !out_q);

    assert_acc_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !div_zero) |=> (acc_q < $past(div_eff)));

    assert_one_toggle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(out_q) || (en_i && $past(en_i) && !$past(div_zero) && $fell(out_q)))
        |-> $past(ev));
  end

  assign clk_o = out_q;
endmodule

// File: rtl/clk_src_frac_div.sv
module clk_src_frac_div
  import clk_src_div_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int INT_BITS    = 12,
  parameter int FRAC_BITS   = 12,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = INT_BITS + FRAC_BITS,
  localparam int DWP        = (DW > 0) ? DW : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REG_W-1:0]   ctrl_i,
  input  logic [REG_W-1:0]   div_i,
  input  logic [NUM_SRC-1:0] src_clk_i,
  output logic               clk_o,
  output logic               busy_o
);
  logic [NUM_SRC-1:0] src_gnd, src_sync;
  logic [DWP-1:0]     div_field;
  logic               en_q, sel_lvl;
  logic               unused_bits;

  assign unused_bits = ^{ctrl_i, div_i, src_clk_i[0]};
  assign src_gnd     = {src_clk_i[NUM_SRC-1:1], 1'b0};

  if (DW > 0) begin : g_field
    assign div_field = div_i[DIV_POINT-FRAC_BITS +: DWP];
  end else begin : g_nofield
    assign div_field = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= ctrl_i[EN_BIT];

  assign busy_o = en_q;

  clk_src_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_gnd),
    .q_o   (src_sync)
  );

  clk_src_switch #(.N(NUM_SRC), .SEL_W(SEL_W)) u_switch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (src_sync),
    .sel_req_i(ctrl_i[SEL_LSB +: SEL_W]),
    .lvl_o    (sel_lvl)
  );

  clk_frac_div #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_q),
    .lvl_i (sel_lvl),
    .div_i (div_field),
    .clk_o (clk_o)
  );

  assert_busy_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[EN_BIT] |=> busy_o);

  assert_busy_drops_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[EN_BIT] |=> !busy_o);

  assert_gated_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !clk_o);

  assert_ground_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_sync[0]);
endmodule

// File: tb/clk_src_frac_div_tb.sv
`timescale 1ns/1ps
module clk_src_frac_div_tb;
  localparam int NSRC = 16;
  localparam int IB   = 4;
  localparam int FB   = 2;
  localparam int ONE  = 1 << FB;
  localparam int WIN  = 3000;
  localparam int NVEC = 11;
  localparam logic [31:0] DIV_JUNK  = 32'hA5A5_0155;
  localparam logic [31:0] CTRL_JUNK = 32'h5A5A_0000;
  localparam int VSEL [NVEC] = '{1, 1, 2, 3, 5, 7, 15, 4, 1, 0, 2};
  localparam int VDIV [NVEC] = '{4, 6, 8, 10, 12, 5, 7, 63, 2, 6, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ctrl = '0, divr = '0;
  logic [NSRC-1:0] src;
  logic clk_o, busy_o, clk_pt, busy_pt;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic s = 1'b0;
    initial forever #((g + 2) * 4) s = ~s;
    assign src[g] = s;
  end

  clk_src_frac_div #(.NUM_SRC(NSRC), .INT_BITS(IB), .FRAC_BITS(FB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .div_i(divr),
    .src_clk_i(src), .clk_o(clk_o), .busy_o(busy_o));

  clk_src_frac_div #(.NUM_SRC(NSRC), .INT_BITS(0), .FRAC_BITS(0)) u_dut_pt (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .div_i(divr),
    .src_clk_i(src), .clk_o(clk_pt), .busy_o(busy_pt));

  task automatic check(input string req, input int act, input int exp, input int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int w, output int n_main, output int n_pt);
    logic pm, pp;
    n_main = 0; n_pt = 0;
    @(negedge clk);
    pm = clk_o; pp = clk_pt;
    repeat (w) begin
      @(negedge clk);
      if (clk_o && !pm) n_main++;
      if (clk_pt && !pp) n_pt++;
      pm = clk_o; pp = clk_pt;
    end
  endtask

  task automatic apply(input int sel, input int d, input bit en);
    @(negedge clk);
    ctrl = CTRL_JUNK | (en ? 32'h10 : 32'h0) | 32'(sel);
    divr = DIV_JUNK | (32'(d) << (12 - FB));
  endtask

  initial begin
    int nm, np, h, deff, exp_m, exp_p;
    repeat (5) @(negedge clk);
    check("R11 clk_o in reset", int'(clk_o), 0, 0);
    check("R11 busy_o in reset", int'(busy_o), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 clk_o after reset", int'(clk_o), 0, 0);
    check("R11 busy_o after reset", int'(busy_o), 0, 0);

    // R1: disabled, valid divisor, running source
    apply(1, 4, 1'b0);
    repeat (50) @(negedge clk);
    measure(1000, nm, np);
    check("R1 no edges while disabled", nm, 0, 0);
    check("R1 no edges while disabled (pass)", np, 0, 0);

    // R2: busy one cycle after enable
    apply(1, 4, 1'b1);
    @(negedge clk);
    check("R2 busy after enable", int'(busy_o), 1, 0);
    apply(1, 4, 1'b0);
    @(negedge clk);
    check("R2 busy after disable", int'(busy_o), 0, 0);

    // table sweep: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      apply(VSEL[v], VDIV[v], 1'b1);
      repeat (400) @(negedge clk);
      measure(WIN, nm, np);
      h     = VSEL[v] + 2;
      deff  = (VDIV[v] < ONE) ? ONE : VDIV[v];
      exp_m = (VSEL[v] == 0 || VDIV[v] == 0) ? 0 : (WIN * ONE) / (2 * h * deff);
      exp_p = (VSEL[v] == 0) ? 0 : WIN / (2 * h);
      if (VDIV[v] == 0)          check("R7 zero divisor stops", nm, 0, 0);
      else if (VSEL[v] == 0)     check("R4 ground source", nm, 0, 0);
      else if (VDIV[v] < ONE)    check("R8 sub-unity clamp", nm, exp_m, 2);
      else                       check("R6 R5 R3 divided rate", nm, exp_m, 2);
      check("R9 pass-through rate", np, exp_p, 2);
    end

    // R10: switch from source 7 to source 1 while running at 1.0
    apply(7, 4, 1'b1);
    repeat (400) @(negedge clk);
    apply(1, 4, 1'b1);
    measure(120, nm, np);
    check("R10 no extra edges across switch", (nm > (120 / 6) + 2) ? 1 : 0, 0, 0);
    repeat (200) @(negedge clk);
    measure(WIN, nm, np);
    check("R10 new source rate after switch", nm, WIN / 6, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule